// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block is the transmit half of a serial audio codec link. Software writes 32-bit words into a data register. Each word becomes either one 20-bit sample or two 20-bit samples taken from its two 16-bit halves. Each sample is left-justified to 20 bits according to the configured sample width. The samples wait in a circular buffer of parameterised depth. Once the buffer is at least half full, transmit is enabled and one of the two audio slots is enabled, the samples leave as stereo pairs over a ready/valid handshake to the frame generator.

The block keeps sticky status flags for empty, half-empty, full and underrun. From these it derives three interrupt bits and one maskable interrupt line. Writing 0 to the interface enable bit of the main control register returns the whole block to its reset state.

Registers are selected by a 3-bit address: 0 main control (bit 0 interface enable), 1 transmit control, 2 status (read only), 3 interrupt mask (bits 2:0), 4 interrupt clear (write only, bit 0 clears underrun), 5 interrupt bits (read only), 6 sample data (write only). Reads of other addresses return 0.

Top module: `aud_tx_fifo`

## Requirements
- R1: After reset, status reads 0x03. Status bits are: bit 0 empty, bit 1 half-empty, bit 2 full, bit 3 underrun, bit 4 busy, where busy means pair_valid is high. After reset the interrupt-bit register reads 0x6, the transmit control and mask registers read 0, irq is low and pair_valid is low.
- R2: Transmit control bits are: bit 0 transmit enable, bit 1 slot-3 enable, bit 2 slot-4 enable, bits 4:3 size code, bit 5 packed mode. Size code 0 means 16 bits, 1 means 18 bits, 2 means 20 bits and 3 means 12 bits. In unpacked mode a data write stores one sample equal to the word shifted left by 4, 2, 0 or 8 bits respectively, truncated to 20 bits.
- R3: In packed mode a data write stores two samples: first the low 16 bits, then the high 16 bits. Each is shifted left by 8 for size code 3 or by 4 otherwise, and truncated to 20 bits.
- R4: A transmit control write that requests packed mode with size code 1 or 2 stores packed mode as 0. The read-back of bit 5 shows the stored value.
- R5: An unpacked write is stored only while the level is below DEPTH and is dropped otherwise. A push that brings the level to DEPTH sets full.
- R6: A packed write is stored only when level + 2 < DEPTH. Otherwise neither half is stored.
- R7: pair_valid is raised only while transmit is enabled, slot 3 or slot 4 is enabled, and the level is at least DEPTH/2. The older sample of each pair is pair_left and the next one is pair_right.
- R8: Once a pair has been accepted, draining continues at one pair per clock, below the half threshold as well, until fewer than two samples remain. pair_valid stays high until accepted unless a register write intervenes.
- R9: A push that leaves a nonzero level clears empty and underrun. A push that leaves the level at DEPTH/2 or more clears half-empty. Full and empty are never both set.
- R10: A drained pair clears full. It sets half-empty when the remaining level is at most DEPTH/2, and sets empty and underrun when the level reaches 0. Empty is set exactly when the level is 0.
- R11: The interrupt-bit register holds underrun in bit 0, half-empty in bit 1, and empty with pair_valid low in bit 2. irq is high when any of these bits is set in the mask register.
- R12: An interrupt-clear write with bit 0 set clears the underrun flag.
- R13: Writing main control with bit 0 equal to 0 clears all registers and the buffer. Status returns to 0x03 and samples held before the write are never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pair_valid | output | 1 | A stereo pair is offered |
| pair_ready | input | 1 | Frame generator accepts the pair |
| pair_left | output | 20 | Left sample |
| pair_right | output | 20 | Right sample |
| irq | output | 1 | Masked interrupt line |

## Verification
A register write takes effect at the clock edge that samples it. Read data, status, pair_valid and irq all come combinationally from registers, so their new values are due within the same cycle, right after that edge. A pair is transferred at the edge where pair_valid and pair_ready are both high, and the next pair or the updated flags appear immediately after it. The bench changes inputs one time unit after a rising edge and samples everything at the following falling edge. Its scoreboard monitor compares each pair at the falling edge before the edge that accepts it.

// File: rtl/aud_tx_pkg.sv
// Shared types for the audio transmit FIFO: register selects, the transmit
// control layout, the sample size codes and the status flag layout.
package aud_tx_pkg;

    localparam int SAMP_W = 20;
    localparam int IRQ_W  = 3;

    typedef enum logic [2:0] {
        A_MAIN  = 3'd0,
        A_TXCTL = 3'd1,
        A_STAT  = 3'd2,
        A_IMASK = 3'd3,
        A_ICLR  = 3'd4,
        A_IRQS  = 3'd5,
        A_DATA  = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ18 = 2'd1,
        SZ20 = 2'd2,
        SZ12 = 2'd3
    } size_e;

    typedef struct packed {
        logic       packed_mode;
        logic [1:0] size;
        logic       slot4;
        logic       slot3;
        logic       en;
    } txctl_t;

    typedef struct packed {
        logic busy;
        logic underrun;
        logic full;
        logic half;
        logic empty;
    } stat_t;

endpackage

// File: rtl/aud_tx_regs.sv
// Register decode for the audio transmit FIFO.
// Holds main enable, transmit control and interrupt mask; produces one-cycle
// strobes for data pushes, underrun clear and the global soft clear.
// Assumes one register access per cycle.
module aud_tx_regs
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic             main_en,
    output txctl_t           txctl,
    output logic [IRQ_W-1:0] imask,
    output logic             soft_clr,
    output logic             data_push,
    output logic             iclr_under
);

    reg_sel_e sel;
    logic     packed_ok;

    // Decode the selected register and the write strobes.
    always_comb begin
        sel        = reg_sel_e'(reg_addr);
        soft_clr   = reg_wr && (sel == A_MAIN) && !reg_wdata[0];
        data_push  = reg_wr && (sel == A_DATA);
        iclr_under = reg_wr && (sel == A_ICLR) && reg_wdata[0];
        packed_ok  = (reg_wdata[4:3] == SZ16) || (reg_wdata[4:3] == SZ12);
    end

    // Hold the configuration registers; a soft clear wipes them all.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            main_en <= 1'b0;
            txctl   <= '0;
            imask   <= '0;
        end else if (reg_wr) begin
            case (sel)
                A_MAIN:  main_en <= reg_wdata[0];
                A_TXCTL: txctl   <= {reg_wdata[5] && packed_ok, reg_wdata[4:0]};
                A_IMASK: imask   <= reg_wdata[IRQ_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/aud_tx_pack.sv
// Sample formatter: turns one 32-bit data word into one or two 20-bit
// left-justified samples according to the size code and packed mode.
// Purely combinational.
module aud_tx_pack
    import aud_tx_pkg::*;
(
    input  logic [31:0]       wdata,
    input  txctl_t            txctl,
    output logic [SAMP_W-1:0] samp0,
    output logic [SAMP_W-1:0] samp1,
    output logic              two
);

    logic [SAMP_W-1:0] lane [2];
    logic [SAMP_W-1:0] single;

    // One formatter per 16-bit half for packed mode.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [15:0] half_w;
        assign half_w = wdata[16*g +: 16];
        // Left-justify one packed half.
        always_comb begin
            if (txctl.size == SZ12) lane[g] = {half_w[11:0], 8'h00};
            else                    lane[g] = {half_w, 4'h0};
        end
    end

    // Left-justify a full word for unpacked mode.
    always_comb begin
        case (size_e'(txctl.size))
            SZ16:    single = {wdata[15:0], 4'h0};
            SZ18:    single = {wdata[17:0], 2'b00};
            SZ20:    single = wdata[19:0];
            default: single = {wdata[11:0], 8'h00};
        endcase
    end

    // Select the pair or the single sample.
    always_comb begin
        two   = txctl.packed_mode;
        samp0 = two ? lane[0] : single;
        samp1 = lane[1];
    end

endmodule

// File: rtl/aud_tx_ring.sv
// Circular sample buffer: up to two samples written and two read per cycle.
// Decides whether a write fits and reports the current and next level.
// Assumes DEPTH is a power of two of at least 8; pops only when level >= 2,
// so the read pointer always points at an even (left) entry.
module aud_tx_ring
    import aud_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_req,
    input  logic              wr_two,
    input  logic [SAMP_W-1:0] samp0,
    input  logic [SAMP_W-1:0] samp1,
    input  logic              pop,
    output logic [1:0]        acc_cnt,
    output logic [$clog2(DEPTH):0] level,
    output logic [$clog2(DEPTH):0] level_nxt,
    output logic [SAMP_W-1:0] left,
    output logic [SAMP_W-1:0] right
);

    localparam int PW = $clog2(DEPTH);
    localparam int LW = PW + 1;

    logic [SAMP_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [LW:0]       room_chk;

    // Decide how many samples of this write are stored.
    always_comb begin
        room_chk = {1'b0, level} + (LW+1)'(2);
        if (!wr_req)     acc_cnt = 2'd0;
        else if (wr_two) acc_cnt = (room_chk < (LW+1)'(DEPTH)) ? 2'd2 : 2'd0;
        else             acc_cnt = (level < LW'(DEPTH)) ? 2'd1 : 2'd0;
        level_nxt = level + LW'(acc_cnt) - (pop ? LW'(2) : LW'(0));
    end

    // Store accepted samples at the write pointer.
    always_ff @(posedge clk) begin
        if (acc_cnt != 2'd0) mem[wptr] <= samp0;
        if (acc_cnt == 2'd2) mem[wptr + PW'(1)] <= samp1;
    end

    // Advance pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            wptr  <= wptr + PW'(acc_cnt);
            rptr  <= rptr + (pop ? PW'(2) : PW'(0));
            level <= level_nxt;
        end
    end

    // Present the oldest pair.
    always_comb begin
        left  = mem[rptr];
        right = mem[rptr + PW'(1)];
    end

endmodule

// File: rtl/aud_tx_drain.sv
// Drain control: offers a pair once the half threshold is reached and keeps
// draining after each accepted pair until fewer than two samples remain.
// Assumes the gate comes from registered configuration.
module aud_tx_drain #(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   gate,
    input  logic [$clog2(DEPTH):0] level,
    input  logic [$clog2(DEPTH):0] level_nxt,
    input  logic                   pair_ready,
    output logic                   pair_valid,
    output logic                   pop
);

    localparam int LW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic burst;

    // Offer a pair and detect the transfer.
    always_comb begin
        pair_valid = gate && (level >= LW'(2)) && ((level >= LW'(HALF)) || burst);
        pop        = pair_valid && pair_ready;
    end

    // Remember that a burst is running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) burst <= 1'b0;
        else if (!gate)    burst <= 1'b0;
        else if (pop)      burst <= (level_nxt >= LW'(2));
    end

endmodule

// File: rtl/aud_tx_flags.sv
// Sticky status flags and interrupt bits. Push effects are applied first,
// then underrun clear, then drain effects, all in the same cycle.
// Assumes pushes and the underrun clear never coincide (one write per cycle).
module aud_tx_flags
    import aud_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [1:0]             acc_cnt,
    input  logic [$clog2(DEPTH):0] level,
    input  logic [$clog2(DEPTH):0] level_nxt,
    input  logic                   pop,
    input  logic                   iclr_under,
    input  logic                   busy,
    input  logic [IRQ_W-1:0]       imask,
    output stat_t                  stat,
    output logic [IRQ_W-1:0]       irq_bits,
    output logic                   irq
);

    localparam int LW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic          empty_q, half_q, full_q, under_q;
    logic          empty_d, half_d, full_d, under_d;
    logic [LW-1:0] lvl_push;

    // Compute next flag values in push, clear, drain order.
    always_comb begin
        empty_d  = empty_q;
        half_d   = half_q;
        full_d   = full_q;
        under_d  = under_q;
        lvl_push = level + LW'(acc_cnt);
        if (acc_cnt != 2'd0) begin
            if (lvl_push != '0) begin
                empty_d = 1'b0;
                under_d = 1'b0;
            end
            if (lvl_push >= LW'(HALF))  half_d = 1'b0;
            if (lvl_push >= LW'(DEPTH)) full_d = 1'b1;
        end
        if (iclr_under) under_d = 1'b0;
        if (pop) begin
            full_d = 1'b0;
            if (level_nxt <= LW'(HALF)) half_d = 1'b1;
            if (level_nxt == '0) begin
                empty_d = 1'b1;
                under_d = 1'b1;
            end
        end
    end

    // Register the flags; reset leaves empty and half-empty set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            empty_q <= 1'b1;
            half_q  <= 1'b1;
            full_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            empty_q <= empty_d;
            half_q  <= half_d;
            full_q  <= full_d;
            under_q <= under_d;
        end
    end

    // Derive status word, interrupt bits and the masked line.
    always_comb begin
        stat     = '{busy: busy, underrun: under_q, full: full_q, half: half_q, empty: empty_q};
        irq_bits = {!busy && empty_q, half_q, under_q};
        irq      = |(irq_bits & imask);
    end

endmodule

// File: rtl/aud_tx_fifo.sv
// Audio transmit FIFO top: register decode, sample formatting, circular
// buffer, drain control and status flags, with a combinational read mux.
// Assumes DEPTH is a power of two from 8 to 2048.
module aud_tx_fifo
    import aud_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pair_valid,
    input  logic              pair_ready,
    output logic [SAMP_W-1:0] pair_left,
    output logic [SAMP_W-1:0] pair_right,
    output logic              irq
);

    localparam int LW = $clog2(DEPTH) + 1;

    logic              main_en, soft_clr, data_push, iclr_under, two, pop, gate;
    txctl_t            txctl;
    logic [IRQ_W-1:0]  imask, irq_bits;
    logic [SAMP_W-1:0] samp0, samp1;
    logic [1:0]        acc_cnt;
    logic [LW-1:0]     lvl, lvl_nxt;
    stat_t             st;

    aud_tx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .main_en(main_en), .txctl(txctl), .imask(imask),
        .soft_clr(soft_clr), .data_push(data_push), .iclr_under(iclr_under)
    );

    aud_tx_pack u_pack (
        .wdata(reg_wdata), .txctl(txctl), .samp0(samp0), .samp1(samp1), .two(two)
    );

    aud_tx_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr_req(data_push), .wr_two(two),
        .samp0(samp0), .samp1(samp1), .pop(pop), .acc_cnt(acc_cnt), .level(lvl),
        .level_nxt(lvl_nxt), .left(pair_left), .right(pair_right)
    );

    // Drain only when enabled and an audio slot is active.
    always_comb gate = txctl.en && (txctl.slot3 || txctl.slot4);

    aud_tx_drain #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .gate(gate), .level(lvl),
        .level_nxt(lvl_nxt), .pair_ready(pair_ready), .pair_valid(pair_valid), .pop(pop)
    );

    aud_tx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .acc_cnt(acc_cnt), .level(lvl),
        .level_nxt(lvl_nxt), .pop(pop), .iclr_under(iclr_under), .busy(pair_valid),
        .imask(imask), .stat(st), .irq_bits(irq_bits), .irq(irq)
    );

    // Return the selected register.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            A_MAIN:  reg_rdata = {31'd0, main_en};
            A_TXCTL: reg_rdata = {26'd0, txctl};
            A_STAT:  reg_rdata = {27'd0, st};
            A_IMASK: reg_rdata = {29'd0, imask};
            A_IRQS:  reg_rdata = {29'd0, irq_bits} & 32'h7F;
            default: reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/aud_tx_fifo_chk.sv
// Assertion checker for aud_tx_fifo, bound to every instance of the top.
module aud_tx_fifo_chk #(
    parameter int DEPTH = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic [2:0]             reg_addr,
    input logic [31:0]            reg_wdata,
    input logic                   pair_valid,
    input logic                   pair_ready,
    input logic [$clog2(DEPTH):0] lvl,
    input logic                   f_empty,
    input logic                   f_full,
    input logic                   f_under
);

    localparam int LW = $clog2(DEPTH) + 1;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= LW'(DEPTH));

    p_valid_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> lvl >= LW'(2));

    p_valid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !pair_ready && !reg_wr) |=> pair_valid);

    p_not_full_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_full && f_empty));

    p_empty_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        f_empty == (lvl == '0));

    p_under_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4 && reg_wdata[0] && !(pair_valid && pair_ready))
        |=> !f_under);

    p_soft_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && !reg_wdata[0]) |=> (lvl == '0 && !pair_valid));

endmodule

bind aud_tx_fifo aud_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .lvl(lvl), .f_empty(st.empty), .f_full(st.full), .f_under(st.underrun)
);

// File: tb/aud_tx_fifo_tb.sv
`timescale 1ns/1ps
module aud_tx_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        pair_valid;
    logic        pair_ready = 1'b0;
    logic [19:0] pair_left, pair_right;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [19:0] expq[$];

    always #2.5 clk = ~clk;

    aud_tx_fifo #(.DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pair_valid(pair_valid),
        .pair_ready(pair_ready), .pair_left(pair_left), .pair_right(pair_right),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end one time unit after a rising edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        check(req, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic push(logic [19:0] v);
        expq.push_back(v);
    endtask

    task automatic drain(int cycles);
        pair_ready = 1'b1;
        repeat (cycles) @(posedge clk);
        #1 pair_ready = 1'b0;
    endtask

    // Scoreboard monitor: compare each pair at the edge before it is taken.
    always @(negedge clk) begin
        if (rst_n && pair_valid && pair_ready) begin
            if (expq.size() < 2) begin
                n_chk++; n_fail++;
                $display("FAIL %s: actual pair %0h/%0h expected none", cur_req, pair_left, pair_right);
            end else begin
                check(cur_req, {12'd0, pair_left},  {12'd0, expq[0]});
                check(cur_req, {12'd0, pair_right}, {12'd0, expq[1]});
                void'(expq.pop_front());
                void'(expq.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        rd_chk("R1", 3'd2, 32'h03);
        rd_chk("R1", 3'd5, 32'h6);
        rd_chk("R1", 3'd1, 32'h0);
        rd_chk("R1", 3'd3, 32'h0);
        check("R1", {31'd0, irq}, 32'd0);
        check("R1", {31'd0, pair_valid}, 32'd0);
        wr(3'd0, 32'h1);
        rd_chk("R1", 3'd0, 32'h1);

        // R11 mask enables the line
        wr(3'd3, 32'h7);
        check("R11", {31'd0, irq}, 32'd1);

        // R2 unpacked 16-bit then 12-bit, R7 threshold, R9 push flags
        cur_req = "R2";
        wr(3'd1, 32'h03);
        wr(3'd6, 32'h1234);     push(20'h12340);
        rd_chk("R9", 3'd2, 32'h02);
        wr(3'd6, 32'hABCD5);    push(20'hBCD50);
        wr(3'd6, 32'h0FFFF);    push(20'hFFFF0);
        rd_chk("R7", 3'd2, 32'h02);
        wr(3'd1, 32'h1B);
        wr(3'd6, 32'h0AB);      push(20'h0AB00);
        rd_chk("R9", 3'd2, 32'h10);
        drain(5);
        check("R2", expq.size(), 0);
        rd_chk("R10", 3'd2, 32'h0B);
        rd_chk("R11", 3'd5, 32'h7);

        // R12 underrun clear
        wr(3'd4, 32'h1);
        rd_chk("R12", 3'd2, 32'h03);
        rd_chk("R12", 3'd5, 32'h6);

        // R2 18 and 20 bit, R4 packed forced off
        wr(3'd1, 32'h0B);
        wr(3'd6, 32'h3FFFF);    push(20'hFFFFC);
        wr(3'd1, 32'h13);
        wr(3'd6, 32'hFEDCBA98); push(20'hCBA98);
        wr(3'd1, 32'h33);
        rd_chk("R4", 3'd1, 32'h13);
        wr(3'd6, 32'h11112222); push(20'h12222);
        wr(3'd1, 32'h2B);
        rd_chk("R4", 3'd1, 32'h0B);
        wr(3'd6, 32'h5);        push(20'h00014);
        drain(5);
        check("R2", expq.size(), 0);

        // R3 packed 16 and 12 bit
        cur_req = "R3";
        wr(3'd1, 32'h23);
        rd_chk("R3", 3'd1, 32'h23);
        wr(3'd6, 32'hBEEF1234); push(20'h12340); push(20'hBEEF0);
        wr(3'd1, 32'h3B);
        wr(3'd6, 32'h0ABC0DEF); push(20'hDEF00); push(20'hABC00);
        drain(5);
        check("R3", expq.size(), 0);

        // R6 packed limit, R5 unpacked limit and full
        cur_req = "R5";
        wr(3'd1, 32'h23);
        wr(3'd6, 32'h00020001); push(20'h00010); push(20'h00020);
        wr(3'd6, 32'h00040003); push(20'h00030); push(20'h00040);
        wr(3'd6, 32'h00060005); push(20'h00050); push(20'h00060);
        wr(3'd6, 32'h00080007);
        rd_chk("R6", 3'd2, 32'h10);
        wr(3'd1, 32'h03);
        wr(3'd6, 32'h7);        push(20'h00070);
        wr(3'd6, 32'h8);        push(20'h00080);
        rd_chk("R5", 3'd2, 32'h14);
        wr(3'd6, 32'h9);
        drain(8);
        check("R5", expq.size(), 0);
        rd_chk("R10", 3'd2, 32'h0B);

        // R7 gating, R8 burst below threshold
        cur_req = "R8";
        wr(3'd1, 32'h02);
        wr(3'd6, 32'h1); push(20'h10);
        wr(3'd6, 32'h2); push(20'h20);
        wr(3'd6, 32'h3); push(20'h30);
        wr(3'd6, 32'h4); push(20'h40);
        wr(3'd6, 32'h5); push(20'h50);
        rd_chk("R7", 3'd2, 32'h00);
        wr(3'd1, 32'h01);
        rd_chk("R7", 3'd2, 32'h00);
        pair_ready = 1'b1;
        wr(3'd1, 32'h05);
        repeat (5) @(posedge clk);
        #1 pair_ready = 1'b0;
        check("R8", expq.size(), 1);
        rd_chk("R10", 3'd2, 32'h02);

        // R13 soft clear
        cur_req = "R13";
        wr(3'd0, 32'h0);
        expq.delete();
        rd_chk("R13", 3'd2, 32'h03);
        rd_chk("R13", 3'd1, 32'h0);
        rd_chk("R13", 3'd3, 32'h0);
        rd_chk("R13", 3'd0, 32'h0);
        check("R13", {31'd0, irq}, 32'd0);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h03);
        wr(3'd6, 32'hA); push(20'hA0);
        wr(3'd6, 32'hB); push(20'hB0);
        wr(3'd6, 32'hC); push(20'hC0);
        wr(3'd6, 32'hD); push(20'hD0);
        drain(5);
        check("R13", expq.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule